// File: doc/BRIEF.md
# Serial TDC Word Receiver

This block takes one serial bit stream from a time-to-digital converter, together with the bit clock that the converter forwards alongside it. It recovers 32-bit words from fixed 36-bit frames. A frame is a zero start bit, then 32 data bits sent most significant bit first, then an odd parity bit, then two stop bits at level one. Between frames the line rests at one. At 40 Mbit/s one bit lasts 25 ns, so a frame takes 900 ns.

Each recovered word carries two flags, one for a parity mismatch and one for a framing fault. The word and its flags cross from the bit clock domain into the system clock domain through a small asynchronous FIFO with Gray-coded pointers. On the system side they appear as a valid/ready stream.

The output follows valid/ready back-pressure rules. While `out_valid` is high and `out_ready` is low, the word and its flags hold steady. An entry leaves the FIFO on any system clock edge where both signals are high. The serial side cannot be stalled. A frame that completes while the FIFO is full is discarded, and a sticky overflow indication is raised.

Top module: `tdc_serial_rx`

## Requirements
- R1: After reset, `out_valid` is 0 and `ovf_flag` is 0.
- R2: While the line stays at 1, no word is produced. A frame begins only at a bit sampled as 0 while the receiver is hunting.
- R3: The 32 bits that follow the start bit form `out_word`, and the first bit received lands in bit 31.
- R4: Parity is odd: the 32 data bits plus the parity bit hold an odd number of ones. If they do not, `out_par_err` is 1 for that word, and otherwise it is 0.
- R5: If either stop bit is 0, `out_frm_err` is 1 for that word. If the first stop bit is 0, hunting resumes at the very next bit, so a start bit in the second stop slot opens a new frame.
- R6: Words leave in arrival order. While `out_valid` is 1 and `out_ready` is 0, `out_word` and both flags stay stable.
- R7: The FIFO holds FIFO_DEPTH (default 4) words. A frame that completes while the FIFO is full is dropped, and `ovf_flag` rises and stays at 1 until reset.
- R8: A start bit that directly follows the second stop bit of the previous frame is accepted, so back-to-back frames with no idle bits are all received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock forwarded with the serial data |
| bit_rst_n | input | 1 | Active-low reset, bit clock domain |
| ser_in | input | 1 | Serial data, sampled on rising bit_clk |
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Active-low reset, system clock domain |
| out_valid | output | 1 | A received word is available |
| out_ready | input | 1 | Consumer accepts the word this cycle |
| out_word | output | 32 | Received data word |
| out_par_err | output | 1 | Parity mismatch on this word |
| out_frm_err | output | 1 | A stop bit of this word was 0 |
| ovf_flag | output | 1 | Sticky: a word was dropped on a full FIFO |

## Verification
The parity check and the stop-bit check are evaluated on the same frame, so one word can carry both faults. The bench provokes this with a frame that has an inverted parity bit and a zero second stop bit. It expects both flags to be set on that one word, and the next clean word to have neither flag. A second case places a zero first stop bit so that a new start bit falls in the next slot. It is judged by receiving both the faulty word and the following word intact.

// File: rtl/tdcrx_pkg.sv
package tdcrx_pkg;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic              par_err;
    logic              frm_err;
    logic [WORD_W-1:0] data;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } rx_state_e;
endpackage

// File: rtl/tdcrx_sync.sv
module tdcrx_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tdcrx_deframer.sv
module tdcrx_deframer
  import tdcrx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ser_in,
  output logic      push,
  output rx_entry_t push_entry
);
  localparam int CNT_W = $clog2(WORD_W);

  rx_state_e         state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] shreg;
  logic              par_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_HUNT;
      bit_cnt    <= '0;
      shreg      <= '0;
      par_bad    <= 1'b0;
      push       <= 1'b0;
      push_entry <= '0;
    end else begin
      push <= 1'b0;
      unique case (state)
        ST_HUNT: begin
          if (!ser_in) begin
            state   <= ST_DATA;
            bit_cnt <= '0;
          end
        end
        ST_DATA: begin
          shreg <= {shreg[WORD_W-2:0], ser_in};
          if (bit_cnt == CNT_W'(WORD_W-1)) state <= ST_PAR;
          else bit_cnt <= bit_cnt + 1'b1;
        end
        ST_PAR: begin
          par_bad <= ~(^{shreg, ser_in});
          state   <= ST_STOP1;
        end
        ST_STOP1: begin
          if (!ser_in) begin
            push       <= 1'b1;
            push_entry <= '{par_err: par_bad, frm_err: 1'b1, data: shreg};
            state      <= ST_HUNT;
          end else begin
            state <= ST_STOP2;
          end
        end
        ST_STOP2: begin
          push       <= 1'b1;
          push_entry <= '{par_err: par_bad, frm_err: ~ser_in, data: shreg};
          state      <= ST_HUNT;
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  // R2: a high line keeps the receiver hunting
  a_r2_idle_stays_hunt: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HUNT && ser_in) |=> (state == ST_HUNT));

  // R5: a zero first stop bit returns to hunting at once
  a_r5_stop1_bad_hunt: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP1 && !ser_in) |=> (state == ST_HUNT && push));
endmodule

// File: rtl/tdcrx_afifo.sv
module tdcrx_afifo #(
  parameter int DW     = 34,
  parameter int DEPTH  = 4,
  parameter int STAGES = 2
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_full,
  input  logic          rclk,
  input  logic          rrst_n,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rgray_w, wgray_r;
  logic [PW-1:0] rbin_w, wdiff;

  tdcrx_sync #(.W(PW), .STAGES(STAGES)) u_rptr_sync (
    .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_w));
  tdcrx_sync #(.W(PW), .STAGES(STAGES)) u_wptr_sync (
    .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_r));

  // write side
  assign rbin_w  = gray2bin(rgray_w);
  assign wdiff   = wbin - rbin_w;
  assign wr_full = (wdiff == PW'(DEPTH));

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_en && !wr_full) begin
      wbin  <= wbin + 1'b1;
      wgray <= (wbin + 1'b1) ^ ((wbin + 1'b1) >> 1);
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_en && !wr_full) mem[wbin[AW-1:0]] <= wr_data;
  end

  // read side
  assign rd_valid = (rgray != wgray_r);
  assign rd_data  = mem[rbin[AW-1:0]];

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rd_valid && rd_ready) begin
      rbin  <= rbin + 1'b1;
      rgray <= (rbin + 1'b1) ^ ((rbin + 1'b1) >> 1);
    end
  end

  // R7: a full FIFO accepts no write
  a_r7_no_write_when_full: assert property (@(posedge wclk) disable iff (!wrst_n)
    wr_full |=> (wbin == $past(wbin)));

  // R7: Gray write pointer moves by at most one bit per edge
  a_r7_gray_step: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  // R6: a stalled output holds its data
  a_r6_hold_stable: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: rtl/tdc_serial_rx.sv
module tdc_serial_rx
  import tdcrx_pkg::*;
#(
  parameter int FIFO_DEPTH  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              bit_clk,
  input  logic              bit_rst_n,
  input  logic              ser_in,
  input  logic              sys_clk,
  input  logic              sys_rst_n,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              out_par_err,
  output logic              out_frm_err,
  output logic              ovf_flag
);
  logic      push;
  rx_entry_t push_entry;
  rx_entry_t pop_entry;
  logic      fifo_full;
  logic      ovf_bit;

  tdcrx_deframer u_deframer (
    .clk(bit_clk), .rst_n(bit_rst_n), .ser_in(ser_in),
    .push(push), .push_entry(push_entry));

  tdcrx_afifo #(.DW(ENTRY_W), .DEPTH(FIFO_DEPTH), .STAGES(SYNC_STAGES)) u_fifo (
    .wclk(bit_clk), .wrst_n(bit_rst_n), .wr_en(push), .wr_data(push_entry),
    .wr_full(fifo_full),
    .rclk(sys_clk), .rrst_n(sys_rst_n), .rd_valid(out_valid),
    .rd_ready(out_ready), .rd_data(pop_entry));

  always_ff @(posedge bit_clk or negedge bit_rst_n) begin
    if (!bit_rst_n)             ovf_bit <= 1'b0;
    else if (push && fifo_full) ovf_bit <= 1'b1;
  end

  tdcrx_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ovf_sync (
    .clk(sys_clk), .rst_n(sys_rst_n), .d(ovf_bit), .q(ovf_flag));

  assign out_word    = pop_entry.data;
  assign out_par_err = pop_entry.par_err;
  assign out_frm_err = pop_entry.frm_err;

  // R7: overflow indication never clears on its own
  a_r7_ovf_sticky: assert property (@(posedge bit_clk) disable iff (!bit_rst_n)
    ovf_bit |=> ovf_bit);

  a_r7_ovf_sticky_sys: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    ovf_flag |=> ovf_flag);
endmodule

// File: tb/tdc_serial_rx_bench.sv
module tdc_serial_rx_bench;
  logic bit_clk = 0, sys_clk = 0;
  logic bit_rst_n = 0, sys_rst_n = 0;
  logic ser_in = 1, out_ready = 0;
  logic out_valid, out_par_err, out_frm_err, ovf_flag;
  logic [31:0] out_word;

  int checks = 0, fails = 0;

  always #2    sys_clk = ~sys_clk;
  always #12.5 bit_clk = ~bit_clk;

  tdc_serial_rx u_tdc_serial_rx (
    .bit_clk(bit_clk), .bit_rst_n(bit_rst_n), .ser_in(ser_in),
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_par_err(out_par_err), .out_frm_err(out_frm_err), .ovf_flag(ovf_flag));

  typedef struct packed {
    logic [31:0] w;
    logic bad_par, bad_s1, bad_s2, exp_pe, exp_fe;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'hA5A5_0F0F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'h8000_0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{32'h1234_5678, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{32'hCAFE_F00D, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{32'h0F1E_2D3C, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    '{32'h0000_0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge bit_clk) ser_in = b;
  endtask

  // short: omit the second stop slot (next frame starts there)
  task automatic send_frame(input logic [31:0] w, input logic bp, input logic b1,
                            input logic b2, input bit short);
    send_bit(1'b0);
    for (int i = 31; i >= 0; i--) send_bit(w[i]);
    send_bit((~^w) ^ bp);
    send_bit(~b1);
    if (!short) send_bit(~b2);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 2000 && !out_valid; i++) @(negedge sys_clk);
  endtask

  task automatic pop();
    @(negedge sys_clk) out_ready = 1;
    @(negedge sys_clk) out_ready = 0;
  endtask

  task automatic expect_word(input logic [31:0] w, input logic pe, input logic fe,
                             input string req);
    wait_valid();
    check(out_valid == 1'b1, {req, " valid"}, 64'(out_valid), 64'd1);
    check(out_word == w, {req, " word"}, 64'(out_word), 64'(w));
    check({out_par_err, out_frm_err} == {pe, fe}, {req, " flags"},
          64'({out_par_err, out_frm_err}), 64'({pe, fe}));
    pop();
  endtask

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge bit_clk);
    // R1: reset state
    check(out_valid == 0, "R1 valid", 64'(out_valid), 0);
    check(ovf_flag == 0, "R1 ovf", 64'(ovf_flag), 0);
    bit_rst_n = 1; sys_rst_n = 1;

    // R2: idle line yields nothing
    idle(50);
    repeat (20) @(negedge sys_clk);
    check(out_valid == 0, "R2 idle", 64'(out_valid), 0);

    // R3 R4 R5 table walk
    foreach (VECS[k]) begin
      send_frame(VECS[k].w, VECS[k].bad_par, VECS[k].bad_s1, VECS[k].bad_s2, 1'b0);
      idle(3);
      expect_word(VECS[k].w, VECS[k].exp_pe, VECS[k].exp_fe, "R3 R4 R5 table");
    end

    // R5: bad first stop bit, next start bit in the second stop slot
    send_frame(32'h1357_9BDF, 1'b0, 1'b1, 1'b0, 1'b1);
    send_frame(32'h2468_ACE0, 1'b0, 1'b0, 1'b0, 1'b0);
    idle(3);
    expect_word(32'h1357_9BDF, 1'b0, 1'b1, "R5 short frame");
    expect_word(32'h2468_ACE0, 1'b0, 1'b0, "R5 resumed frame");

    // R8: back-to-back frames, R6 ordering and stall hold
    send_frame(32'h0000_00AA, 1'b0, 1'b0, 1'b0, 1'b0);
    send_frame(32'h0000_00BB, 1'b0, 1'b0, 1'b0, 1'b0);
    send_frame(32'h0000_00CC, 1'b0, 1'b0, 1'b0, 1'b0);
    idle(3);
    wait_valid();
    repeat (20) @(negedge sys_clk);
    check(out_valid && out_word == 32'h0000_00AA, "R6 hold", 64'(out_word), 64'hAA);
    expect_word(32'h0000_00AA, 1'b0, 1'b0, "R8 first");
    expect_word(32'h0000_00BB, 1'b0, 1'b0, "R8 second");
    expect_word(32'h0000_00CC, 1'b0, 1'b0, "R8 third");

    // R7: overflow
    check(ovf_flag == 0, "R7 ovf before", 64'(ovf_flag), 0);
    for (int i = 0; i < 5; i++) begin
      send_frame(32'hD000_0000 + 32'(i), 1'b0, 1'b0, 1'b0, 1'b0);
      idle(1);
    end
    idle(3);
    repeat (10) @(negedge sys_clk);
    check(ovf_flag == 1, "R7 ovf set", 64'(ovf_flag), 1);
    for (int i = 0; i < 4; i++)
      expect_word(32'hD000_0000 + 32'(i), 1'b0, 1'b0, "R7 drain");
    repeat (20) @(negedge sys_clk);
    check(out_valid == 0, "R7 fifth dropped", 64'(out_valid), 0);
    check(ovf_flag == 1, "R7 ovf sticky", 64'(ovf_flag), 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule